// File: doc/BRIEF.md
# Dual Countdown Timer with Sleep Wake-Up

This peripheral holds two independent down-counters that share a common control scheme. A narrow counter (4 bits by default) steps on a divided slow tick. A wide counter (32 bits by default) steps on every fast tick. One run bit, held in the wide counter's control register, gates both counters. Software reaches all four registers through a simple single-cycle read/write port. Reads are combinational.

Each counter is watched through its top bit. When that bit is set, the counter can raise a level interrupt, latch a sticky service-request flag, and wake a processor that reports it is in shutdown. The wake-enable bit that allowed a wake-up clears itself, so the wake output is a single-cycle pulse. While the global interrupt enable and the wide counter's interrupt enable are both on, the wide counter will not count past all-ones once its top bit is set. It parks there until software reloads it.

Register map (2-bit address): 0 = narrow count, 1 = narrow control, 2 = wide count, 3 = wide control. Control fields are bit 0 run (wide counter only), bit 1 wake-enable, bit 2 interrupt-enable and bit 3 service-request (read-only).

Top module: `dual_cdtimer`

## Requirements
- R1: After reset, all four registers read zero and `irq` and `wake` are low.
- R2: While run (bit 0 at address 3) is 1, each `fast_tick` cycle decrements the wide count (address 2) by one, wrapping 0 to all-ones when saturation (R8) is not in force. With run at 0 the count does not change.
- R3: While run is 1, the narrow count (address 0) decrements modulo 16 once every `T1_DIV` cycles in which `slow_tick` is high. With run at 0 it does not change.
- R4: Writing address 0 with the value it already holds changes neither the count nor the slow-tick prescaler phase. Writing a different value loads it and clears the prescaler, so the next decrement needs a full `T1_DIV` slow ticks.
- R5: Service-request (control bit 3) reads 0 one cycle after the counter's top bit is 0. It reads 1 one cycle after a cycle in which the top bit is 1 and wake-enable (bit 1) or interrupt-enable (bit 2) is 1. Otherwise it holds. Register writes never change it.
- R6: `irq` is high exactly while some counter has its top bit at 1, interrupt-enable at 1, and either `cpu_sleep` low or wake-enable at 1.
- R7: When a counter's top bit is 1, `cpu_sleep` is high and its wake-enable is 1, `wake` is high for exactly one cycle in the next cycle. The same wake-enable then reads 0.
- R8: When `glob_ie` is high, the wide interrupt-enable is 1, `cpu_sleep` is low or the wide wake-enable is 1, and the wide top bit is 1, the wide count becomes all-ones in the next cycle and stays there.
- R9: A narrow control register has no run bit. Its bit 0 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | Base tick for the narrow counter's prescaler |
| fast_tick | input | 1 | Step enable for the wide counter |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | T2_W | Write data |
| reg_rdata | output | T2_W | Read data for `reg_addr`, combinational |
| cpu_sleep | input | 1 | Processor is in shutdown |
| glob_ie | input | 1 | Global interrupt enable |
| irq | output | 1 | Level interrupt request |
| wake | output | 1 | One-cycle wake-up pulse |

## Verification
The bench targets four corner cases.

- Wrap through zero and parking. The wide counter is driven from zero to all-ones, then driven again with saturation armed. It is also loaded with a bare top-bit value while armed. A design that misorders load, park and step would either keep counting or fail to snap to all-ones.
- Same-value narrow write. A narrow write repeating the current value is issued mid-prescaler-period. It must keep the prescaler phase, while a different value must restart it. Getting this wrong shifts the next decrement by two ticks.
- Sleep gating. The interrupt must drop in shutdown unless wake-enable is set.
- Wake pulse. The wake sequence must give exactly one pulse and then clear wake-enable. A design that forgets the self-clear would hold `wake` high.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int CTRL_W  = 4;
  localparam int CB_RUN  = 0;
  localparam int CB_WKE  = 1;
  localparam int CB_INTR = 2;
  localparam int CB_SRQ  = 3;

  typedef enum logic [1:0] {
    A_T1_CNT = 2'd0,
    A_T1_CTL = 2'd1,
    A_T2_CNT = 2'd2,
    A_T2_CTL = 2'd3
  } reg_addr_e;

  // Next service-request value from the top bit and enables.
  function automatic logic srq_next(input logic msb, input logic wke,
                                    input logic intr, input logic cur);
    if (!msb)              return 1'b0;
    else if (wke || intr)  return 1'b1;
    else                   return cur;
  endfunction

  // Interrupt condition with shutdown gating.
  function automatic logic irq_cond(input logic msb, input logic intr,
                                    input logic wke, input logic sleep);
    return msb && intr && (!sleep || wke);
  endfunction
endpackage

// File: rtl/dct_prescaler.sv
module dct_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic restart,
  output logic step
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt_q;

  assign step = adv && !restart && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (restart)      cnt_q <= '0;
    else if (adv)          cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/dct_counter.sv
module dct_counter #(
  parameter int W         = 32,
  parameter bit SAT_EN    = 1'b0,
  parameter bit SKIP_SAME = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         step,
  input  logic         sat_arm,
  output logic [W-1:0] cnt,
  output logic         loaded
);
  logic [W-1:0] cnt_q;
  logic         sat_hit;

  generate
    if (SKIP_SAME) begin : g_skip
      assign loaded = wr_en && (wdata != cnt_q);
    end else begin : g_plain
      assign loaded = wr_en;
    end
    if (SAT_EN) begin : g_sat
      assign sat_hit = sat_arm && cnt_q[W-1];
    end else begin : g_nosat
      logic unused_arm;
      assign unused_arm = sat_arm;
      assign sat_hit    = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (loaded)   cnt_q <= wdata;
    else if (sat_hit)  cnt_q <= '1;
    else if (step)     cnt_q <= cnt_q - 1'b1;
  end

  assign cnt = cnt_q;

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_hit && !loaded) |=> (cnt_q == '1)); // R8
  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_en && !sat_hit) |=> (cnt_q == W'($past(cnt_q) - 1'b1))); // R2
  AST_SAME_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !loaded && !step && !sat_hit) |=> $stable(cnt_q)); // R4
endmodule

// File: rtl/dct_ctrl.sv
module dct_ctrl
  import dct_pkg::*;
#(
  parameter bit HAS_RUN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              msb,
  input  logic              sleep,
  output logic [CTRL_W-1:0] ctrl_rd,
  output logic              wke,
  output logic              intr,
  output logic              irq_req,
  output logic              wake_out
);
  logic wke_q, intr_q, srq_q, wake_q, run_q;
  logic fire;
  logic unused_srq_bit;

  assign unused_srq_bit = wdata[CB_SRQ];
  assign fire = msb && sleep && wke_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wke_q  <= 1'b0;
      intr_q <= 1'b0;
      srq_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      srq_q  <= srq_next(msb, wke_q, intr_q, srq_q);
      wake_q <= fire;
      if (wr_en) begin
        wke_q  <= wdata[CB_WKE];
        intr_q <= wdata[CB_INTR];
      end else if (fire) begin
        wke_q  <= 1'b0;
      end
    end
  end

  generate
    if (HAS_RUN) begin : g_run
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     run_q <= 1'b0;
        else if (wr_en) run_q <= wdata[CB_RUN];
      end
    end else begin : g_norun
      logic unused_run_bit;
      assign unused_run_bit = wdata[CB_RUN];
      assign run_q = 1'b0;
    end
  endgenerate

  always_comb begin
    ctrl_rd          = '0;
    ctrl_rd[CB_RUN]  = run_q;
    ctrl_rd[CB_WKE]  = wke_q;
    ctrl_rd[CB_INTR] = intr_q;
    ctrl_rd[CB_SRQ]  = srq_q;
  end

  assign wke      = wke_q;
  assign intr     = intr_q;
  assign irq_req  = irq_cond(msb, intr_q, wke_q, sleep);
  assign wake_out = wake_q;

  AST_SRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !msb |=> !srq_q); // R5
  AST_SRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (msb && (wke_q || intr_q)) |=> srq_q); // R5
  AST_WAKE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !wr_en) |=> (!wke_q && wake_q)); // R7
  AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_q && !$past(wr_en)) |=> !wake_q); // R7
endmodule

// File: rtl/dual_cdtimer.sv
module dual_cdtimer
  import dct_pkg::*;
#(
  parameter int T1_W   = 4,
  parameter int T2_W   = 32,
  parameter int T1_DIV = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            slow_tick,
  input  logic            fast_tick,
  input  logic            reg_wr,
  input  logic [1:0]      reg_addr,
  input  logic [T2_W-1:0] reg_wdata,
  output logic [T2_W-1:0] reg_rdata,
  input  logic            cpu_sleep,
  input  logic            glob_ie,
  output logic            irq,
  output logic            wake
);
  localparam int PAD_T1 = T2_W - T1_W;
  localparam int PAD_CT = T2_W - CTRL_W;

  logic wr_t1c, wr_t1x, wr_t2c, wr_t2x;
  logic run, t1_step, t1_loaded, t2_loaded, t2_arm;
  logic [T1_W-1:0] t1_cnt;
  logic [T2_W-1:0] t2_cnt;
  logic [CTRL_W-1:0] t1_ctl, t2_ctl;
  logic t1_wke, t1_intr, t2_wke, t2_intr;
  logic t1_irq, t2_irq, t1_wake, t2_wake;

  assign wr_t1c = reg_wr && (reg_addr == A_T1_CNT);
  assign wr_t1x = reg_wr && (reg_addr == A_T1_CTL);
  assign wr_t2c = reg_wr && (reg_addr == A_T2_CNT);
  assign wr_t2x = reg_wr && (reg_addr == A_T2_CTL);

  assign run    = t2_ctl[CB_RUN];
  assign t2_arm = glob_ie && t2_intr && (!cpu_sleep || t2_wke);

  dct_prescaler #(.DIV(T1_DIV)) i_pre (
    .clk(clk), .rst_n(rst_n), .adv(run && slow_tick),
    .restart(t1_loaded), .step(t1_step));

  dct_counter #(.W(T1_W), .SAT_EN(1'b0), .SKIP_SAME(1'b1)) i_t1 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_t1c), .wdata(reg_wdata[T1_W-1:0]),
    .step(t1_step), .sat_arm(1'b0), .cnt(t1_cnt), .loaded(t1_loaded));

  dct_counter #(.W(T2_W), .SAT_EN(1'b1), .SKIP_SAME(1'b0)) i_t2 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_t2c), .wdata(reg_wdata),
    .step(run && fast_tick), .sat_arm(t2_arm), .cnt(t2_cnt),
    .loaded(t2_loaded));

  dct_ctrl #(.HAS_RUN(1'b0)) i_c1 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_t1x), .wdata(reg_wdata[CTRL_W-1:0]),
    .msb(t1_cnt[T1_W-1]), .sleep(cpu_sleep), .ctrl_rd(t1_ctl),
    .wke(t1_wke), .intr(t1_intr), .irq_req(t1_irq), .wake_out(t1_wake));

  dct_ctrl #(.HAS_RUN(1'b1)) i_c2 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_t2x), .wdata(reg_wdata[CTRL_W-1:0]),
    .msb(t2_cnt[T2_W-1]), .sleep(cpu_sleep), .ctrl_rd(t2_ctl),
    .wke(t2_wke), .intr(t2_intr), .irq_req(t2_irq), .wake_out(t2_wake));

  always_comb begin
    unique case (reg_addr)
      A_T1_CNT: reg_rdata = {{PAD_T1{1'b0}}, t1_cnt};
      A_T1_CTL: reg_rdata = {{PAD_CT{1'b0}}, t1_ctl};
      A_T2_CNT: reg_rdata = t2_cnt;
      default:  reg_rdata = {{PAD_CT{1'b0}}, t2_ctl};
    endcase
  end

  assign irq  = t1_irq || t2_irq;
  assign wake = t1_wake || t2_wake;

  AST_SLEEP_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_sleep && !t1_wke && !t2_wke) |-> !irq); // R6
  AST_T1_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_t1c) |=> $stable(t1_cnt)); // R3
  AST_T2_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_t2c && !t2_arm) |=> $stable(t2_cnt)); // R2
  AST_T1_NORUN: assert property (@(posedge clk) disable iff (!rst_n)
    t1_ctl[CB_RUN] == 1'b0); // R9
  AST_LOAD_T2: assert property (@(posedge clk) disable iff (!rst_n)
    t2_loaded |=> (t2_cnt == $past(reg_wdata))); // R2
endmodule

// File: tb/test_dual_cdtimer.sv
module test_dual_cdtimer;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slow_tick = 1'b0, fast_tick = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic cpu_sleep = 1'b0, glob_ie = 1'b0;
  logic irq, wake;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_cdtimer #(.T1_W(4), .T2_W(32), .T1_DIV(DIV)) i_dual_cdtimer (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cpu_sleep(cpu_sleep), .glob_ie(glob_ie),
    .irq(irq), .wake(wake));

  // behavioural reference state
  logic [3:0]  m_t1;
  logic [31:0] m_t2;
  int          m_pre;
  logic m_run, m_wke1, m_int1, m_srq1, m_wke2, m_int2, m_srq2, m_wake;
  logic h1, h2, f1, f2, ar;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_t1 = 0; m_t2 = 0; m_pre = 0; m_run = 0; m_wake = 0;
      m_wke1 = 0; m_int1 = 0; m_srq1 = 0; m_wke2 = 0; m_int2 = 0; m_srq2 = 0;
    end else begin
      h1 = m_t1[3]; h2 = m_t2[31];
      f1 = h1 && cpu_sleep && m_wke1;
      f2 = h2 && cpu_sleep && m_wke2;
      ar = glob_ie && m_int2 && (!cpu_sleep || m_wke2);
      m_wake = f1 || f2;
      if (!h1) m_srq1 = 0; else if (m_wke1 || m_int1) m_srq1 = 1;
      if (!h2) m_srq2 = 0; else if (m_wke2 || m_int2) m_srq2 = 1;
      // narrow counter uses the run bit as it was before this edge
      if (reg_wr && reg_addr == 2'd0 && reg_wdata[3:0] != m_t1) begin
        m_t1 = reg_wdata[3:0]; m_pre = 0;
      end else if (m_run && slow_tick) begin
        if (m_pre == DIV - 1) begin m_pre = 0; m_t1 = m_t1 - 1; end
        else m_pre++;
      end
      if (reg_wr && reg_addr == 2'd2) m_t2 = reg_wdata;
      else if (ar && h2) m_t2 = 32'hFFFF_FFFF;
      else if (m_run && fast_tick) m_t2 = m_t2 - 1;
      if (reg_wr && reg_addr == 2'd1) begin
        m_wke1 = reg_wdata[1]; m_int1 = reg_wdata[2];
      end else if (f1) m_wke1 = 0;
      if (reg_wr && reg_addr == 2'd3) begin
        m_wke2 = reg_wdata[1]; m_int2 = reg_wdata[2]; m_run = reg_wdata[0];
      end else if (f2) m_wke2 = 0;
    end
  end

  function automatic logic [31:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return {28'd0, m_t1};
      2'd1: return {28'd0, m_srq1, m_int1, m_wke1, 1'b0};
      2'd2: return m_t2;
      default: return {28'd0, m_srq2, m_int2, m_wke2, m_run};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("R6 irq vs model", {31'd0, irq},
          {31'd0, (m_t1[3] && m_int1 && (!cpu_sleep || m_wke1)) ||
                  (m_t2[31] && m_int2 && (!cpu_sleep || m_wke2))});
      chk("R7 wake vs model", {31'd0, wake}, {31'd0, m_wake});
      chk("R2/R3 readback vs model", reg_rdata, m_read(reg_addr));
    end
  end

  task automatic do_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic do_rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic fticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); fast_tick = 1; @(negedge clk); fast_tick = 0;
    end
  endtask

  task automatic sticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slow_tick = 1; @(negedge clk); slow_tick = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      do_rd(2'(a), v); chk("R1 reset register", v, 0);
    end
    chk("R1 reset irq/wake", {30'd0, irq, wake}, 0);

    // R2 counting and wrap
    do_wr(2'd2, 32'd3);
    do_wr(2'd3, 32'h1);
    fticks(3);
    do_rd(2'd2, v); chk("R2 count to zero", v, 0);
    fticks(1);
    do_rd(2'd2, v); chk("R2 wrap to all-ones", v, 32'hFFFF_FFFF);
    do_rd(2'd3, v); chk("R5 srq holds without enables", v, 32'h1);

    // R5/R6 interrupt enable
    do_wr(2'd3, 32'h5);
    @(negedge clk);
    do_rd(2'd3, v); chk("R5 srq set", v, 32'hD);
    chk("R6 irq raised", {31'd0, irq}, 1);
    do_wr(2'd2, 32'd2);
    @(negedge clk);
    do_rd(2'd3, v); chk("R5 srq cleared by msb 0", v, 32'h5);
    chk("R6 irq dropped", {31'd0, irq}, 0);

    // R8 saturation
    glob_ie = 1;
    fticks(3);
    fticks(2);
    do_rd(2'd2, v); chk("R8 parked at all-ones", v, 32'hFFFF_FFFF);
    do_wr(2'd2, 32'h8000_0000);
    @(negedge clk);
    do_rd(2'd2, v); chk("R8 snap to all-ones", v, 32'hFFFF_FFFF);
    glob_ie = 0;
    fticks(1);
    do_rd(2'd2, v); chk("R2 resumes when disarmed", v, 32'hFFFF_FFFE);

    // R6 sleep gating, R7 wake
    cpu_sleep = 1;
    #1 chk("R6 irq masked in sleep", {31'd0, irq}, 0);
    do_wr(2'd3, 32'h7);
    #1 chk("R6 irq with wake-enable in sleep", {31'd0, irq}, 1);
    @(negedge clk); #1;
    chk("R7 wake pulse", {31'd0, wake}, 1);
    do_rd(2'd3, v); chk("R7 wake-enable self-cleared", v, 32'hD);
    @(negedge clk); #1;
    chk("R7 wake lasts one cycle", {31'd0, wake}, 0);
    cpu_sleep = 0;
    do_wr(2'd3, 32'h1);

    // R3/R4 narrow counter and prescaler
    do_wr(2'd0, 32'd9);
    sticks(4);
    do_rd(2'd0, v); chk("R3 one step per DIV ticks", v, 32'd8);
    sticks(2);
    do_wr(2'd0, 32'd8);
    sticks(2);
    do_rd(2'd0, v); chk("R4 same write keeps phase", v, 32'd7);
    sticks(2);
    do_wr(2'd0, 32'd5);
    sticks(2);
    do_rd(2'd0, v); chk("R4 new write restarts prescaler", v, 32'd5);
    sticks(2);
    do_rd(2'd0, v); chk("R3 step after full period", v, 32'd4);

    // R9 no run bit in narrow control, R6/R5 on narrow counter
    do_wr(2'd1, 32'h5);
    do_rd(2'd1, v); chk("R9 narrow bit0 reads zero", v, 32'h4);
    chk("R6 no irq with msb 0", {31'd0, irq}, 0);
    do_wr(2'd0, 32'hC);
    #1 chk("R6 narrow irq", {31'd0, irq}, 1);
    @(negedge clk);
    do_rd(2'd1, v); chk("R5 narrow srq", v, 32'hC);

    // run off: nothing counts
    do_wr(2'd3, 32'h0);
    fticks(2); sticks(4);
    do_rd(2'd0, v); chk("R3 stopped", v, 32'hC);
    do_rd(2'd2, v); chk("R2 stopped", v, 32'hFFFF_FFFE);

    // R5 write cannot set srq
    do_wr(2'd2, 32'd1);
    @(negedge clk);
    do_wr(2'd3, 32'h8);
    @(negedge clk);
    do_rd(2'd3, v); chk("R5 srq not writable", v, 32'h0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule